// File: doc/BRIEF.md
# Serially controlled clock fan-out with per-output gating

This block takes one reference clock and drives eighteen copies of it. Each copy can be switched off, and a switched-off copy is held at a steady low level. A single global enable pin puts every output driver into high impedance at once. The per-output switches are written over a two-wire I2C bus. The block acts only as a receiving slave and supports no reads. The I2C lines are oversampled by a fast system clock.

A transfer starts with a START condition and the 7-bit address, with the direction bit at 0. Up to three bytes follow, and they fill three 8-bit enable registers in a fixed order. There is no index byte, so a register can only be reached by writing the ones before it. Enable changes cross into the reference clock domain. There they are applied only while the reference clock is low, so no output ever shows a shortened high pulse.

Inside the block, the receiver hands each completed byte to the enable bank as a one-cycle valid strobe. The bank accepts a byte in every cycle, so there is no ready and no back-pressure. At the bus edge, the only flow control is the ACK bit. A byte that is not acknowledged is dropped.

Top module: `clkfan_ctrl`

## Requirements
- R1: The block acknowledges an address byte only when its upper 7 bits equal the `DEV_ADDR` parameter and its bit 0 (direction) is 0. Acknowledging means pulling SDA low during the ninth clock. After an address that is not acknowledged, no byte is acknowledged and no enable changes until the next START.
- R2: After an acknowledged address, the first data byte sets outputs 0 to 7, the second sets outputs 8 to 15, and bits 1:0 of the third set outputs 16 and 17. Bit n of a byte maps to the lowest-numbered output of that group plus n. Bits 7:2 of the third byte are ignored.
- R3: The enables change only on an accepted data byte. Data bytes after the third are acknowledged and have no effect on any output.
- R4: After reset every enable is 1, so all 18 outputs follow the reference clock.
- R5: An output whose enable bit is 0 stays at a low level and does not toggle.
- R6: When `outs_enable` is 0, all bits of `fan_drv` are 0 and every output is in high impedance. When `outs_enable` is 1, all bits of `fan_drv` are 1.
- R7: Every data byte that follows an acknowledged address is acknowledged in its ninth clock.
- R8: A START or a repeated START makes the next data byte go to the first register again. A STOP ends the transfer, and the registers already written keep their new values.
- R9: An enable change takes effect only while the reference clock is low. Every high pulse on an output is as long as the high phase of the reference clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock used to oversample the bus |
| sys_rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | I2C clock line as seen at the pin |
| sda_in | input | 1 | I2C data line as seen at the pin |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain ACK) |
| ref_clk | input | 1 | Reference clock to be distributed |
| outs_enable | input | 1 | 1 drives the outputs, 0 puts them in high impedance |
| fan_clk | output | 18 | Gated copies of the reference clock |
| fan_drv | output | 18 | Driver enable for each output (1 = driven) |

## Verification
Each output pattern is loaded over the bus, and the bench then counts the rising edges and the high levels on every output. Several patterns are used:
- A single byte, three bytes and a fourth byte separate the register order and the discard of extra bytes.
- A wrong address and a read request must leave the outputs unchanged, which shows the filtering.
- A repeated START in the middle of a frame must send the next byte back to the first register.
- An all-zero low byte shows that disabled outputs stay low while the upper registers keep their earlier values.

Throughout the run, every output high pulse is timed against the reference high phase, which catches enable changes that are not applied cleanly.

// File: rtl/clkfan_pkg.sv
`timescale 1ns/1ps
package clkfan_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_DATA,
    ST_DACK,
    ST_SKIP
  } rx_state_t;
endpackage

// File: rtl/clkfan_line_sync.sv
`timescale 1ns/1ps
module clkfan_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_s,
  output logic line_prev
);
  logic [STAGES:0] pipe;

  // Bus lines idle high, so the chain resets to 1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '1;
    else        pipe <= {pipe[STAGES-1:0], line_in};
  end

  assign line_s    = pipe[STAGES-1];
  assign line_prev = pipe[STAGES];
endmodule

// File: rtl/clkfan_i2c_rx.sv
`timescale 1ns/1ps
module clkfan_i2c_rx
  import clkfan_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h52,
  parameter int NUM_REGS = 3,
  parameter int IDXW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_s,
  input  logic            scl_p,
  input  logic            sda_s,
  input  logic            sda_p,
  output logic            sda_pull,
  output logic            wr_valid,
  output logic [IDXW-1:0] wr_idx,
  output logic [BYTE_W-1:0] wr_data
);
  localparam int CNTW = $clog2(BYTE_W + 1);
  localparam int SEQW = $clog2(NUM_REGS + 1);
  localparam logic [CNTW-1:0] FULL = CNTW'(BYTE_W);
  localparam logic [SEQW-1:0] LAST = SEQW'(NUM_REGS);

  rx_state_t         state;
  logic [CNTW-1:0]   bitcnt;
  logic [SEQW-1:0]   seq;
  logic [BYTE_W-1:0] sr;

  logic start_c, stop_c, scl_rise, scl_fall;
  assign start_c  = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_c   = scl_s & scl_p & ~sda_p & sda_s;
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bitcnt   <= '0;
      seq      <= '0;
      sr       <= '0;
      sda_pull <= 1'b0;
      wr_valid <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= 1'b0;
      if (start_c) begin
        state    <= ST_ADDR;
        bitcnt   <= '0;
        seq      <= '0;
        sda_pull <= 1'b0;
      end else if (stop_c) begin
        state    <= ST_IDLE;
        sda_pull <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: begin
            if (scl_rise) begin
              sr     <= {sr[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == FULL) begin
              if (sr[BYTE_W-1:1] == DEV_ADDR && !sr[0]) begin
                sda_pull <= 1'b1;
                state    <= ST_AACK;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              bitcnt   <= '0;
              state    <= ST_DATA;
            end
          end
          ST_DATA: begin
            if (scl_rise) begin
              sr     <= {sr[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == FULL) begin
              sda_pull <= 1'b1;
              state    <= ST_DACK;
              if (seq < LAST) begin
                wr_valid <= 1'b1;
                wr_idx   <= seq[IDXW-1:0];
                wr_data  <= sr;
                seq      <= seq + 1'b1;
              end
            end
          end
          ST_DACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              bitcnt   <= '0;
              state    <= ST_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/clkfan_enable_bank.sv
`timescale 1ns/1ps
module clkfan_enable_bank
  import clkfan_pkg::*;
#(
  parameter int NUM_OUT = 18,
  parameter int IDXW = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  input  logic [IDXW-1:0]    wr_idx,
  input  logic [BYTE_W-1:0]  wr_data,
  output logic [NUM_OUT-1:0] en_bits
);
  for (genvar b = 0; b < NUM_OUT; b++) begin : g_bit
    localparam int RSEL = b / BYTE_W;
    localparam int RBIT = b % BYTE_W;
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b1;
      else if (wr_valid && wr_idx == IDXW'(RSEL)) q <= wr_data[RBIT];
    end
    assign en_bits[b] = q;
  end
endmodule

// File: rtl/clkfan_gate.sv
`timescale 1ns/1ps
module clkfan_gate #(
  parameter int NUM_OUT = 18
) (
  input  logic               ref_clk,
  input  logic               rst_n,
  input  logic               outs_enable,
  input  logic [NUM_OUT-1:0] en_bits,
  output logic [NUM_OUT-1:0] fan_clk,
  output logic [NUM_OUT-1:0] fan_drv
);
  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    logic meta, hold;
    // Both stages move on the falling edge, so the gate only changes
    // while the reference is low.
    always_ff @(negedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
        meta <= 1'b1;
        hold <= 1'b1;
      end else begin
        meta <= en_bits[g];
        hold <= meta;
      end
    end
    assign fan_clk[g] = ref_clk & hold;
    assign fan_drv[g] = outs_enable;
  end
endmodule

// File: rtl/clkfan_ctrl.sv
`timescale 1ns/1ps
module clkfan_ctrl
  import clkfan_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h52,
  parameter int NUM_OUT = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic               sys_clk,
  input  logic               sys_rst_n,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_pull,
  input  logic               ref_clk,
  input  logic               outs_enable,
  output logic [NUM_OUT-1:0] fan_clk,
  output logic [NUM_OUT-1:0] fan_drv
);
  localparam int NUM_REGS = (NUM_OUT + BYTE_W - 1) / BYTE_W;
  localparam int IDXW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic scl_s, scl_p, sda_s, sda_p;
  logic wr_valid;
  logic [IDXW-1:0] wr_idx;
  logic [BYTE_W-1:0] wr_data;
  logic [NUM_OUT-1:0] en_bits;

  clkfan_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(sys_clk), .rst_n(sys_rst_n), .line_in(scl_in),
    .line_s(scl_s), .line_prev(scl_p)
  );

  clkfan_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(sys_clk), .rst_n(sys_rst_n), .line_in(sda_in),
    .line_s(sda_s), .line_prev(sda_p)
  );

  clkfan_i2c_rx #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS), .IDXW(IDXW)) u_rx (
    .clk(sys_clk), .rst_n(sys_rst_n),
    .scl_s(scl_s), .scl_p(scl_p), .sda_s(sda_s), .sda_p(sda_p),
    .sda_pull(sda_pull), .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  clkfan_enable_bank #(.NUM_OUT(NUM_OUT), .IDXW(IDXW)) u_bank (
    .clk(sys_clk), .rst_n(sys_rst_n), .wr_valid(wr_valid),
    .wr_idx(wr_idx), .wr_data(wr_data), .en_bits(en_bits)
  );

  clkfan_gate #(.NUM_OUT(NUM_OUT)) u_gate (
    .ref_clk(ref_clk), .rst_n(sys_rst_n), .outs_enable(outs_enable),
    .en_bits(en_bits), .fan_clk(fan_clk), .fan_drv(fan_drv)
  );
endmodule

// File: rtl/clkfan_ctrl_chk.sv
`timescale 1ns/1ps
module clkfan_ctrl_chk #(
  parameter int NUM_OUT = 18,
  parameter int NUM_REGS = 3,
  parameter int IDXW = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scl_s,
  input logic               sda_pull,
  input logic               wr_valid,
  input logic [IDXW-1:0]    wr_idx,
  input logic [NUM_OUT-1:0] en_bits
);
  // R4: enables are all set when reset is released
  a_r4_reset_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (&en_bits));

  // R3: no write strobe means the enables hold
  a_r3_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> $stable(en_bits));

  // R2: only the existing registers are ever addressed
  a_r2_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (int'(wr_idx) < NUM_REGS));

  // R7: the ACK pull starts while the bus clock is low
  a_r7_ack_on_low_scl: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_s);
endmodule

bind clkfan_ctrl clkfan_ctrl_chk #(.NUM_OUT(NUM_OUT), .NUM_REGS(NUM_REGS), .IDXW(IDXW)) u_chk (
  .clk(sys_clk), .rst_n(sys_rst_n), .scl_s(scl_s), .sda_pull(sda_pull),
  .wr_valid(wr_valid), .wr_idx(wr_idx), .en_bits(en_bits)
);

// File: tb/test_clkfan_ctrl.sv
`timescale 1ns/1ps
module test_clkfan_ctrl;
  localparam int NOUT = 18;
  localparam logic [6:0] ADDR = 7'h52;
  localparam int Q = 200;

  logic sys_clk = 1'b0, rst_n = 1'b0, ref_clk = 1'b0, oe = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_pull, sda_line;
  logic [NOUT-1:0] fan_clk, fan_drv;

  assign sda_line = m_sda & ~sda_pull;

  always #5 sys_clk = ~sys_clk;
  initial begin #3; forever #20 ref_clk = ~ref_clk; end

  clkfan_ctrl #(.DEV_ADDR(ADDR), .NUM_OUT(NOUT)) i_clkfan_ctrl (
    .sys_clk(sys_clk), .sys_rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
    .sda_pull(sda_pull), .ref_clk(ref_clk), .outs_enable(oe),
    .fan_clk(fan_clk), .fan_drv(fan_drv)
  );

  int vectors = 0, miscompares = 0;

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  // ---------------- output edge monitor ----------------
  int rises [NOUT];
  realtime rise_t [NOUT];
  logic [NOUT-1:0] high_seen, prev_out = '0;
  bit window = 0;
  int short_pulses = 0;

  always @(fan_clk) begin
    for (int i = 0; i < NOUT; i++) begin
      if (fan_clk[i] === 1'b1 && prev_out[i] === 1'b0) begin
        rise_t[i] = $realtime;
        if (window) rises[i]++;
      end
      if (fan_clk[i] === 1'b0 && prev_out[i] === 1'b1 && ($realtime - rise_t[i]) < 19.5)
        short_pulses++;
      if (window && fan_clk[i] === 1'b1) high_seen[i] = 1'b1;
    end
    prev_out = fan_clk;
  end

  // ---------------- scoreboard ----------------
  typedef struct { string req; logic [NOUT-1:0] mask; } item_t;
  item_t sbq[$];
  bit mon_busy = 0;
  logic [NOUT-1:0] model = '1;

  initial begin
    forever begin
      item_t it;
      logic [NOUT-1:0] obs;
      wait (sbq.size() > 0);
      mon_busy = 1;
      it = sbq.pop_front();
      #400;
      for (int i = 0; i < NOUT; i++) rises[i] = 0;
      high_seen = '0;
      window = 1;
      #400;
      window = 0;
      for (int i = 0; i < NOUT; i++) obs[i] = (rises[i] >= 2);
      check({it.req, " toggling outputs"}, 32'(obs), 32'(it.mask));
      check({it.req, " disabled outputs held low"}, 32'(high_seen & ~it.mask), 32'h0);
      mon_busy = 0;
    end
  end

  task automatic expect_outputs(string req);
    item_t it;
    it.req = req;
    it.mask = model;
    sbq.push_back(it);
    #1;
    wait (sbq.size() == 0 && !mon_busy);
  endtask

  function automatic void apply(int k, logic [7:0] d);
    for (int b = 0; b < 8; b++)
      if (k * 8 + b < NOUT) model[k*8+b] = d[b];
  endfunction

  // ---------------- bus driver ----------------
  task automatic i2c_start();
    m_sda = 0; #Q; m_scl = 0; #Q;
  endtask

  task automatic i2c_rstart();
    m_sda = 1; #Q; m_scl = 1; #Q; m_sda = 0; #Q; m_scl = 0; #Q;
  endtask

  task automatic i2c_stop();
    m_sda = 0; #Q; m_scl = 1; #Q; m_sda = 1; #(2*Q);
  endtask

  task automatic i2c_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; #Q; m_scl = 1; #(2*Q); m_scl = 0; #Q;
    end
    m_sda = 1; #Q; m_scl = 1; #Q;
    acked = (sda_line === 1'b0);
    #Q; m_scl = 0; #Q;
  endtask

  task automatic frame(string req, input logic [6:0] a, input logic rd,
                       input logic [7:0] d0, d1, d2, d3, input int n, input logic exp_ack);
    logic ack;
    logic [7:0] d [4];
    d[0] = d0; d[1] = d1; d[2] = d2; d[3] = d3;
    i2c_start();
    i2c_byte({a, rd}, ack);
    check({req, " address ack"}, 32'(ack), 32'(exp_ack));
    for (int k = 0; k < n; k++) begin
      i2c_byte(d[k], ack);
      check({req, " data ack"}, 32'(ack), 32'(exp_ack));
      if (exp_ack && k < 3) apply(k, d[k]);
    end
    i2c_stop();
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge sys_clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  // ---------------- stimulus ----------------
  initial begin
    logic ack;
    repeat (5) @(posedge sys_clk);
    #1 rst_n = 1;
    #20;
    check("R4 no ack pull after reset", 32'(sda_pull), 32'h0);
    check("R6 drivers on with outs_enable high", 32'(fan_drv), 32'h3FFFF);
    expect_outputs("R4 reset");

    frame("R2 single byte", ADDR, 1'b0, 8'hA5, 8'h00, 8'h00, 8'h00, 1, 1'b1);
    expect_outputs("R2 first register");

    frame("R7 four bytes", ADDR, 1'b0, 8'h0F, 8'hF0, 8'hFE, 8'h00, 4, 1'b1);
    expect_outputs("R3 fourth byte discarded, R2 order");

    frame("R1 wrong address", 7'h53, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 2, 1'b0);
    expect_outputs("R1 wrong address ignored");

    frame("R1 read request", ADDR, 1'b1, 8'h00, 8'h00, 8'h00, 8'h00, 1, 1'b0);
    expect_outputs("R1 read request ignored");

    // R8: repeated START restarts at the first register
    i2c_start();
    i2c_byte({ADDR, 1'b0}, ack); check("R8 address ack", 32'(ack), 32'h1);
    i2c_byte(8'h33, ack); check("R8 data ack", 32'(ack), 32'h1); apply(0, 8'h33);
    i2c_rstart();
    i2c_byte({ADDR, 1'b0}, ack); check("R8 address ack after repeat", 32'(ack), 32'h1);
    i2c_byte(8'h55, ack); check("R8 data ack", 32'(ack), 32'h1); apply(0, 8'h55);
    i2c_byte(8'h03, ack); check("R8 data ack", 32'(ack), 32'h1); apply(1, 8'h03);
    i2c_stop();
    expect_outputs("R8 repeated start");

    frame("R5 low byte off", ADDR, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 1, 1'b1);
    expect_outputs("R5 disabled held low, R8 others kept");

    oe = 0; #20;
    check("R6 drivers off with outs_enable low", 32'(fan_drv), 32'h0);
    oe = 1; #20;
    check("R6 drivers back on", 32'(fan_drv), 32'h3FFFF);

    frame("R9 stress a", ADDR, 1'b0, 8'hFF, 8'h00, 8'h01, 8'h00, 3, 1'b1);
    frame("R9 stress b", ADDR, 1'b0, 8'h5A, 8'hC3, 8'h02, 8'h00, 3, 1'b1);
    expect_outputs("R9 after toggling");
    frame("R4 restore", ADDR, 1'b0, 8'hFF, 8'hFF, 8'hFF, 8'h00, 3, 1'b1);
    expect_outputs("R4 all enabled again");

    check("R9 no shortened output pulse", 32'(short_pulses), 32'h0);
    finish_run();
  end
endmodule